// File: doc/BRIEF.md
# Packed String Match Unit

This unit compares two packed vector operands element by element in every combination and turns the result into a match mask. One operand (A) holds a reference set, range list or substring. The other (B) holds the text to search. A six-bit control word selects several things. It sets whether the operands hold bytes or 16-bit words, and whether elements are signed or unsigned. It picks one of four ways of folding the comparison matrix into a per-element mask, and it sets an optional polarity change on that mask. Each operand has its own length input, so elements at or beyond that length are treated as padding.

For every accepted request, the unit returns the final mask one clock later, along with three status bits. It also returns the position of the lowest set bit in the mask. When no bit is set, that position is the element count. A search engine or string-scan pipeline issues one request per cycle with `in_vld`, and reads the result when `out_vld` is high.

Top module: `xstr_match_unit`

## Requirements
- R1: `ctrl[0]`=0 treats each operand as NB bytes, with element i at bits [8i+7:8i]. `ctrl[0]`=1 treats it as NB/2 16-bit words, with element i at bits [16i+15:16i]. In word mode, mask bits NB-1..NB/2 are always 0.
- R2: `ctrl[1]`=0 compares elements as unsigned. `ctrl[1]`=1 compares them as two's-complement signed.
- R3: An element whose index is at or above its operand's length input is invalid. A length greater than the element count is treated as the element count.
- R4: With `ctrl[3:2]`=00 (set match), mask bit j is 1 when valid B[j] equals some valid A[i].
- R5: With `ctrl[3:2]`=01 (range match), mask bit j is 1 when some pair of valid elements A[2k], A[2k+1] satisfies A[2k] <= B[j] <= A[2k+1], with B[j] valid.
- R6: With `ctrl[3:2]`=10 (lane match), mask bit i is A[i]==B[i] when both are valid. It is 1 when both are invalid and 0 when exactly one is invalid.
- R7: With `ctrl[3:2]`=11 (substring match), mask bit j is 1 when every valid A[k] equals B[j+k] for all j+k below the element count. A B position at or beyond B's length fails, and an A position beyond A's length always passes.
- R8: `ctrl[5:4]` sets the polarity. 00 and 10 leave the mask as it is. 01 inverts every bit below the element count. 11 inverts only the bits below B's length.
- R9: `res_idx` is the index of the lowest set bit of the final mask. It is the element count (16 or 8) when the mask is zero.
- R10: `flag_c` is 1 when the final mask is nonzero. `flag_z` is 1 when B's clamped length is below the element count. `flag_s` is 1 when A's clamped length is below the element count.
- R11: Results appear on the clock edge after `in_vld`, with `out_vld` high for one cycle. The outputs hold their values while `in_vld` is low. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request strobe |
| ctrl | input | 6 | [0] word size, [1] signed, [3:2] fold mode, [5:4] polarity |
| opa | input | VEC_W (128) | Operand A (set, ranges or substring) |
| opb | input | VEC_W (128) | Operand B (searched text) |
| len_a | input | LEN_W (5) | Valid element count of A |
| len_b | input | LEN_W (5) | Valid element count of B |
| out_vld | output | 1 | Result valid |
| res_mask | output | NB (16) | Final match mask |
| res_idx | output | LEN_W (5) | Lowest set-bit index, or element count |
| flag_c | output | 1 | Mask nonzero |
| flag_z | output | 1 | B shorter than element count |
| flag_s | output | 1 | A shorter than element count |

## Verification
The bench builds the unit with the default width of 128 bits, which gives 16 byte lanes and 8 word lanes. Both lane counts are reached at run time through `ctrl[0]`, so a single build covers the word-mode masking of the upper mask half, length clamping at 8 and at 16, and the substring match at the last lane. This width also reaches the range-pair boundaries and the signed/unsigned split at the 0x80/0x8000 values.

// File: rtl/xstr_pkg.sv
package xstr_pkg;
   typedef enum logic [1:0] {
      AGG_ANY   = 2'b00,
      AGG_RANGE = 2'b01,
      AGG_EACH  = 2'b10,
      AGG_ORDER = 2'b11
   } agg_mode_e;

   typedef enum logic [1:0] {
      POL_KEEP       = 2'b00,
      POL_FLIP       = 2'b01,
      POL_KEEP_ALT   = 2'b10,
      POL_FLIP_VALID = 2'b11
   } pol_e;

   typedef struct packed {
      pol_e      pol;
      agg_mode_e agg;
      logic      sgn;
      logic      wide;
   } ctrl_t;
endpackage

// File: rtl/xstr_unpack.sv
module xstr_unpack #(
   parameter int VEC_W = 128,
   parameter int NB    = VEC_W / 8,
   parameter int LEN_W = $clog2(NB + 1)
) (
   input  logic [VEC_W-1:0]     vec,
   input  logic [LEN_W-1:0]     len,
   input  logic                 wide,
   input  logic                 sgn,
   output logic [NB-1:0][16:0]  elem,
   output logic [NB-1:0]        valid,
   output logic [LEN_W-1:0]     cnt
);
   localparam int NW = NB / 2;

   logic [LEN_W-1:0] nel;
   assign nel = wide ? LEN_W'(NW) : LEN_W'(NB);
   assign cnt = (len > nel) ? nel : len;

   for (genvar gi = 0; gi < NB; gi++) begin : g_el
      logic [7:0]  b;
      logic [15:0] w;
      assign b = vec[8*gi +: 8];
      if (gi < NW) begin : g_w
         assign w = vec[16*gi +: 16];
      end else begin : g_nw
         assign w = '0;
      end
      // sign- or zero-extend to a common 17-bit signed form
      assign elem[gi]  = wide ? {sgn & w[15], w} : {{9{sgn & b[7]}}, b};
      assign valid[gi] = LEN_W'(gi) < cnt;
   end
endmodule

// File: rtl/xstr_matrix.sv
module xstr_matrix #(
   parameter int NB = 16
) (
   input  logic [NB-1:0][16:0]       ea,
   input  logic [NB-1:0][16:0]       eb,
   input  logic                      ranges,
   output logic [NB-1:0][NB-1:0]     bres
);
   for (genvar gj = 0; gj < NB; gj++) begin : g_b
      for (genvar gi = 0; gi < NB; gi++) begin : g_a
         logic signed [16:0] av, bv;
         assign av = ea[gi];
         assign bv = eb[gj];
         if (gi % 2 == 0) begin : g_lo
            assign bres[gj][gi] = ranges ? (bv >= av) : (bv == av);
         end else begin : g_hi
            assign bres[gj][gi] = ranges ? (bv <= av) : (bv == av);
         end
      end
   end
endmodule

// File: rtl/xstr_fold.sv
module xstr_fold
   import xstr_pkg::*;
#(
   parameter int NB    = 16,
   parameter int LEN_W = $clog2(NB + 1)
) (
   input  logic [NB-1:0][NB-1:0] bres,
   input  logic [NB-1:0]         va,
   input  logic [NB-1:0]         vb,
   input  agg_mode_e             agg,
   input  logic [LEN_W-1:0]      nel,
   output logic [NB-1:0]         ires
);
   localparam int CW = $clog2(2 * NB);

   for (genvar gj = 0; gj < NB; gj++) begin : g_j
      logic [NB-1:0]   hit_any, ord_t;
      logic [NB/2-1:0] hit_rng;
      logic            each_b, r, in_lane;

      for (genvar gi = 0; gi < NB; gi++) begin : g_any
         assign hit_any[gi] = va[gi] & vb[gj] & bres[gj][gi];
      end
      for (genvar gk = 0; gk < NB/2; gk++) begin : g_rng
         assign hit_rng[gk] = va[2*gk+1] & vb[gj] & bres[gj][2*gk] & bres[gj][2*gk+1];
      end
      for (genvar gk = 0; gk < NB; gk++) begin : g_ord
         if (gj + gk < NB) begin : g_in
            assign ord_t[gk] = (CW'(gj + gk) >= CW'(nel)) | ~va[gk]
                               | (vb[gj+gk] & bres[gj+gk][gk]);
         end else begin : g_out
            assign ord_t[gk] = 1'b1;
         end
      end
      assign each_b  = (va[gj] & vb[gj]) ? bres[gj][gj] : (~va[gj] & ~vb[gj]);
      assign in_lane = LEN_W'(gj) < nel;

      always_comb begin
         case (agg)
            AGG_ANY:   r = |hit_any;
            AGG_RANGE: r = |hit_rng;
            AGG_EACH:  r = each_b;
            default:   r = &ord_t;
         endcase
      end
      assign ires[gj] = r & in_lane;
   end
endmodule

// File: rtl/xstr_match_unit.sv
module xstr_match_unit
   import xstr_pkg::*;
#(
   parameter  int VEC_W = 128,
   localparam int NB    = VEC_W / 8,
   localparam int NW    = NB / 2,
   localparam int LEN_W = $clog2(NB + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [5:0]       ctrl,
   input  logic [VEC_W-1:0] opa,
   input  logic [VEC_W-1:0] opb,
   input  logic [LEN_W-1:0] len_a,
   input  logic [LEN_W-1:0] len_b,
   output logic             out_vld,
   output logic [NB-1:0]    res_mask,
   output logic [LEN_W-1:0] res_idx,
   output logic             flag_c,
   output logic             flag_z,
   output logic             flag_s
);
   if (VEC_W % 16 != 0 || VEC_W < 32 || VEC_W > 256) begin : g_bad_width
      $error("xstr_match_unit: VEC_W must be a multiple of 16 in 32..256");
   end

   ctrl_t cw;
   assign cw = ctrl_t'(ctrl);

   logic [NB-1:0][16:0]   ea, eb;
   logic [NB-1:0]         va, vb, ires, fin, emask;
   logic [LEN_W-1:0]      ca, cb, nel, idx;
   logic [NB-1:0][NB-1:0] bres;

   assign nel = cw.wide ? LEN_W'(NW) : LEN_W'(NB);
   for (genvar gi = 0; gi < NB; gi++) begin : g_em
      assign emask[gi] = LEN_W'(gi) < nel;
   end

   xstr_unpack #(.VEC_W(VEC_W), .NB(NB), .LEN_W(LEN_W)) u_ua (
      .vec(opa), .len(len_a), .wide(cw.wide), .sgn(cw.sgn),
      .elem(ea), .valid(va), .cnt(ca));
   xstr_unpack #(.VEC_W(VEC_W), .NB(NB), .LEN_W(LEN_W)) u_ub (
      .vec(opb), .len(len_b), .wide(cw.wide), .sgn(cw.sgn),
      .elem(eb), .valid(vb), .cnt(cb));

   xstr_matrix #(.NB(NB)) u_mx (
      .ea(ea), .eb(eb), .ranges(cw.agg == AGG_RANGE), .bres(bres));

   xstr_fold #(.NB(NB), .LEN_W(LEN_W)) u_fd (
      .bres(bres), .va(va), .vb(vb), .agg(cw.agg), .nel(nel), .ires(ires));

   always_comb begin
      case (cw.pol)
         POL_FLIP:       fin = ~ires & emask;
         POL_FLIP_VALID: fin = ires ^ vb;
         default:        fin = ires;
      endcase
   end

   always_comb begin
      idx = nel;
      for (int i = NB - 1; i >= 0; i--) begin
         if (fin[i]) idx = LEN_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         res_mask <= '0;
         res_idx  <= '0;
         flag_c   <= 1'b0;
         flag_z   <= 1'b0;
         flag_s   <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            res_mask <= fin;
            res_idx  <= idx;
            flag_c   <= |fin;
            flag_z   <= cb < nel;
            flag_s   <= ca < nel;
         end
      end
   end
endmodule

// File: rtl/xstr_match_chk.sv
module xstr_match_chk #(
   parameter  int VEC_W = 128,
   localparam int NB    = VEC_W / 8,
   localparam int NW    = NB / 2,
   localparam int LEN_W = $clog2(NB + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_vld,
   input logic             wide_in,
   input logic [LEN_W-1:0] len_a,
   input logic [LEN_W-1:0] len_b,
   input logic             out_vld,
   input logic [NB-1:0]    res_mask,
   input logic [LEN_W-1:0] res_idx,
   input logic             flag_c,
   input logic             flag_z,
   input logic             flag_s
);
   logic             s_wide;
   logic [LEN_W-1:0] s_la, s_lb, s_nel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_wide <= 1'b0;
         s_la   <= '0;
         s_lb   <= '0;
      end else if (in_vld) begin
         s_wide <= wide_in;
         s_la   <= len_a;
         s_lb   <= len_b;
      end
   end
   assign s_nel = s_wide ? LEN_W'(NW) : LEN_W'(NB);

   p_word_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && s_wide |-> res_mask[NB-1:NW] == '0);
   p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> res_idx <= s_nel);
   p_idx_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && res_mask == '0 |-> res_idx == s_nel);
   p_idx_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && res_mask != '0 |->
         res_mask[res_idx] && ((res_mask & ((NB'(1) << res_idx) - NB'(1))) == '0));
   p_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> flag_c == (res_mask != '0));
   p_zflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> flag_z == (s_lb < s_nel));
   p_sflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> flag_s == (s_la < s_nel));
   p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld && $stable(res_mask) && $stable(res_idx));
endmodule

bind xstr_match_unit xstr_match_chk #(.VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .wide_in(ctrl[0]),
   .len_a(len_a), .len_b(len_b), .out_vld(out_vld), .res_mask(res_mask),
   .res_idx(res_idx), .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s));

// File: tb/xstr_match_unit_tb.sv
module xstr_match_unit_tb;
   localparam int VW = 128;
   localparam int NB = 16;
   localparam int LW = 5;

   logic          clk = 1'b0;
   logic          rst_n, in_vld;
   logic [5:0]    ctrl;
   logic [VW-1:0] opa, opb;
   logic [LW-1:0] len_a, len_b;
   logic          o_vld, o_c, o_z, o_s;
   logic [NB-1:0] o_mask;
   logic [LW-1:0] o_idx;
   int            n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   xstr_match_unit #(.VEC_W(VW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .ctrl(ctrl),
      .opa(opa), .opb(opb), .len_a(len_a), .len_b(len_b),
      .out_vld(o_vld), .res_mask(o_mask), .res_idx(o_idx),
      .flag_c(o_c), .flag_z(o_z), .flag_s(o_s));

   function automatic logic [VW-1:0] str(input string s);
      logic [VW-1:0] r = '0;
      for (int i = 0; i < s.len() && i < NB; i++) r[8*i +: 8] = s[i];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [5:0] c, input logic [VW-1:0] a, input int la,
                        input logic [VW-1:0] b, input int lb, input logic [15:0] em,
                        input int ei, input logic ec, input logic ez, input logic es,
                        input string tag);
      @(negedge clk);
      ctrl = c; opa = a; opb = b; len_a = LW'(la); len_b = LW'(lb); in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      chk({tag, " R11 out_vld"}, 32'(o_vld), 32'd1);
      chk({tag, " mask"},        32'(o_mask), 32'(em));
      chk({tag, " R9 index"},    32'(o_idx), 32'(ei));
      chk({tag, " R10 c"},       32'(o_c), 32'(ec));
      chk({tag, " R10 z"},       32'(o_z), 32'(ez));
      chk({tag, " R10 s"},       32'(o_s), 32'(es));
   endtask

   task automatic t_reset();
      rst_n = 1'b0; in_vld = 1'b0; ctrl = '0; opa = '0; opb = '0; len_a = '0; len_b = '0;
      repeat (3) @(negedge clk);
      chk("R11 reset out_vld", 32'(o_vld), 0);
      chk("R11 reset mask", 32'(o_mask), 0);
      chk("R11 reset idx/flags", {o_idx, o_c, o_z, o_s}, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_set_match();
      // R4 set match, R3 'h' beyond A length ignored
      apply(6'h00, str("aeiouh"), 5, str("hello world"), 11, 16'h0092, 1, 1, 1, 1, "R4 R3 set");
      // R3 length above count clamps to 16
      apply(6'h00, str("aeiouh"), 5, str("hello world"), 30, 16'h0092, 1, 1, 0, 1, "R3 clamp");
   endtask

   task automatic t_ranges();
      apply(6'h04, str("az"), 2, str("Hi Bob9"), 7, 16'h0032, 1, 1, 1, 1, "R5 ranges");
      // R2: range 0x80..0x7F empty unsigned, full signed
      apply(6'h04, 128'h7F80, 2, 128'h1080, 2, 16'h0000, 16, 0, 1, 1, "R2 unsigned bytes");
      apply(6'h06, 128'h7F80, 2, 128'h1080, 2, 16'h0003, 0, 1, 1, 1, "R2 signed bytes");
      apply(6'h07, {96'h0, 16'h0100, 16'hFF00}, 2, {80'h0, 16'h8000, 16'h0200, 16'hFFFF}, 3,
            16'h0001, 0, 1, 1, 1, "R2 R5 signed words");
      apply(6'h05, {96'h0, 16'h0100, 16'hFF00}, 2, {80'h0, 16'h8000, 16'h0200, 16'hFFFF}, 3,
            16'h0000, 8, 0, 1, 1, "R2 R5 unsigned words");
   endtask

   task automatic t_each_polarity();
      apply(6'h08, str("abcdxf"), 6, str("abcdef"), 6, 16'hFFEF, 0, 1, 1, 1, "R6 lanes");
      apply(6'h08, str("abcd"), 4, str("abcdef"), 6, 16'hFFCF, 0, 1, 1, 1, "R6 one invalid");
      apply(6'h18, str("abcdxf"), 6, str("abcdef"), 6, 16'h0010, 4, 1, 1, 1, "R8 flip all");
      apply(6'h28, str("abcdxf"), 6, str("abcdef"), 6, 16'hFFEF, 0, 1, 1, 1, "R8 keep alt");
      apply(6'h38, str("abcdxf"), 6, str("abcdef"), 6, 16'hFFD0, 4, 1, 1, 1, "R8 flip valid");
   endtask

   task automatic t_substring();
      apply(6'h0C, str("lo"), 2, str("hello world"), 11, 16'h0008, 3, 1, 1, 1, "R7 inner");
      apply(6'h0C, str("pq"), 2, str("abcdefghijklmnop"), 16, 16'h8000, 15, 1, 0, 1, "R7 last lane");
      apply(6'h0C, str("d!"), 2, str("hello world"), 11, 16'h0000, 16, 0, 1, 1, "R7 past B end");
      apply(6'h0C, str(""), 0, str("abcdefghijklmnop"), 16, 16'hFFFF, 0, 1, 0, 1, "R7 empty A");
   endtask

   task automatic t_words();
      apply(6'h01, {96'h0, 16'hABCD, 16'h1234}, 2,
            {64'h0, 16'h0000, 16'h1234, 16'hABCD, 16'h3412}, 20, 16'h0006, 1, 1, 0, 1, "R1 R3 words");
      apply(6'h01, {96'h0, 16'hABCD, 16'h1234}, 2, 128'h0, 3, 16'h0000, 8, 0, 1, 1, "R1 R9 none");
      apply(6'h11, {96'h0, 16'hABCD, 16'h1234}, 2, 128'h0, 3, 16'h00FF, 0, 1, 1, 1, "R1 R8 flip words");
   endtask

   task automatic t_hold();
      logic [NB-1:0] m;
      apply(6'h00, str("aeiou"), 5, str("hello world"), 11, 16'h0092, 1, 1, 1, 1, "R11 pre-hold");
      m = o_mask;
      @(negedge clk);
      ctrl = 6'h18; opa = str("zz");
      @(negedge clk);
      chk("R11 out_vld drops", 32'(o_vld), 0);
      chk("R11 mask held", 32'(o_mask), 32'(m));
      chk("R11 idx held", 32'(o_idx), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R11 watchdog: act=timeout exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_set_match();
      t_ranges();
      t_each_polarity();
      t_substring();
      t_words();
      t_hold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule